// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This unit takes one IEEE-754 binary operand (half, single or double precision) and returns the integral value in the same format that a chosen rounding mode produces. Narrow operands sit in the low bits of a 64-bit bus, and results come back in the same place. A 3-bit rounding-control field picks the mode. It can name one of four fixed modes or nearest-with-ties-away. It can also defer to a 2-bit dynamic mode input, in a variant that reports inexactness or one that stays silent.

Each strobe on `in_valid` yields one registered response on the following clock edge. The response carries the result, an inexact flag, an invalid-operation flag for signalling NaNs, and an undefined flag for reserved encodings. The unit has no flow control: a new operand may arrive every cycle.

Top module: `fp_rint_unit`

## Requirements
- R1: `fmt` selects the format: 2'b00 single (bits 31:0), 2'b01 double (bits 63:0), 2'b11 half (bits 15:0). 2'b10 is reserved: the response has `undef`=1, `result`=0 and both other flags 0.
- R2: When `rctl[2]`=0, `rctl[1:0]` picks a fixed mode: 00 nearest with ties to even, 01 toward +infinity, 10 toward -infinity, 11 toward zero.
- R3: `rctl`=3'b100 rounds to nearest with ties away from zero.
- R4: `rctl`=3'b101 is reserved: `undef`=1, `result`=0, `inexact`=0, `invalid`=0.
- R5: `rctl`=3'b110 and 3'b111 both round with `dyn_mode` (same encoding as R2). Only 3'b110 may raise `inexact`. Fixed modes, ties-away and 3'b111 never raise it.
- R6: Under `rctl`=3'b110, `inexact` is 1 exactly when the result differs numerically from the operand.
- R7: A zero or an infinity is returned unchanged with its sign, and `inexact` stays 0.
- R8: A NaN is returned with its quiet bit (the top fraction bit) forced to 1. `invalid` is 1 when that bit was 0 on input. `inexact` stays 0.
- R9: An operand whose unbiased exponent is at least the fraction width is returned unchanged, without `inexact`.
- R10: A finite nonzero magnitude below one, subnormals included, rounds to zero or to one. A zero result keeps the operand's sign.
- R11: The response appears on the rising edge after the strobe with `out_valid`=1. `out_valid` is 0 in every cycle that follows a cycle without a strobe.
- R12: For half and single, result bits above the format width are 0, and operand bits above the format width have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| fmt | input | 2 | Format select |
| rctl | input | 3 | Rounding-control field |
| dyn_mode | input | 2 | Dynamic rounding mode |
| operand | input | 64 | Operand, right-aligned |
| out_valid | output | 1 | Response strobe |
| result | output | 64 | Rounded value, right-aligned |
| inexact | output | 1 | Result differs from operand (exact variant only) |
| invalid | output | 1 | Signalling NaN seen |
| undef | output | 1 | Reserved format or control encoding |

## Verification
The properties assume that `fmt`, `rctl` and `operand` are meaningful only in cycles where `in_valid` is high. They relate each strobe to the response one edge later and take nothing for granted about idle cycles. The stimulus holds inputs from one falling edge to the next, and it drives values other than the strobe only while the strobe is asserted. It mixes back-to-back strobes with idle gaps, so the one-cycle latency and the idle behaviour are both exercised.

// File: rtl/fp_rint_pkg.sv
package fp_rint_pkg;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_UP        = 3'd1,
    RM_DOWN      = 3'd2,
    RM_ZERO      = 3'd3,
    RM_NEAR_AWAY = 3'd4
  } rmode_e;

  localparam logic [1:0] FMT_SINGLE = 2'b00;
  localparam logic [1:0] FMT_DOUBLE = 2'b01;
  localparam logic [1:0] FMT_RSVD   = 2'b10;
  localparam logic [1:0] FMT_HALF   = 2'b11;

  // Increment decision from the dropped bits: guard is the first dropped
  // bit, sticky the OR of all below it, lsb the lowest kept bit.
  function automatic logic rnd_incr(rmode_e m, logic neg, logic lsb,
                                    logic guard, logic sticky);
    logic r;
    case (m)
      RM_NEAR_EVEN: r = guard & (sticky | lsb);
      RM_NEAR_AWAY: r = guard;
      RM_UP:        r = ~neg & (guard | sticky);
      RM_DOWN:      r = neg & (guard | sticky);
      default:      r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fp_rint_decode.sv
module fp_rint_decode
  import fp_rint_pkg::*;
(
  input  logic [2:0] rctl,
  input  logic [1:0] dyn_mode,
  output rmode_e     mode,
  output logic       exact_en,
  output logic       rctl_undef
);

  always_comb begin
    mode       = RM_NEAR_EVEN;
    exact_en   = 1'b0;
    rctl_undef = 1'b0;
    if (!rctl[2]) begin
      mode = rmode_e'({1'b0, rctl[1:0]});
    end else begin
      case (rctl[1:0])
        2'b00: mode = RM_NEAR_AWAY;
        2'b01: rctl_undef = 1'b1;
        2'b10: begin
          mode     = rmode_e'({1'b0, dyn_mode});
          exact_en = 1'b1;
        end
        default: mode = rmode_e'({1'b0, dyn_mode});
      endcase
    end
  end

endmodule

// File: rtl/fp_rint_core.sv
module fp_rint_core
  import fp_rint_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  input  rmode_e                mode,
  output logic [EXP_W+FRAC_W:0] res,
  output logic                  inexact_raw,
  output logic                  snan
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int MW   = FRAC_W + 2;
  localparam int SH_W = $clog2(FRAC_W + 2);
  localparam logic [MW-1:0]    ONE_M   = MW'(1);
  localparam logic [EXP_W-1:0] ONE_EXP = EXP_W'(BIAS);

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  int                ue;
  logic [SH_W-1:0]   sh;
  logic [MW-1:0]     mant, mask, low_mask, sum;
  logic              up, guard, sticky, lsb;

  assign sgn = op[EXP_W+FRAC_W];
  assign ex  = op[EXP_W+FRAC_W-1:FRAC_W];
  assign fr  = op[FRAC_W-1:0];
  assign ue  = int'(ex) - BIAS;

  always_comb begin
    res         = op;
    inexact_raw = 1'b0;
    snan        = 1'b0;
    sh          = '0;
    mant        = '0;
    mask        = '0;
    low_mask    = '0;
    sum         = '0;
    up          = 1'b0;
    guard       = 1'b0;
    sticky      = 1'b0;
    lsb         = 1'b0;
    if (ex == '1) begin
      if (fr != '0) begin
        snan            = ~fr[FRAC_W-1];
        res[FRAC_W-1]   = 1'b1;
      end
    end else if (ex == '0 && fr == '0) begin
      res = op;
    end else if (ue >= FRAC_W) begin
      res = op;
    end else if (ue < 0) begin
      inexact_raw = 1'b1;
      guard       = (ue == -1);
      sticky      = (ue == -1) ? (fr != '0) : 1'b1;
      up          = rnd_incr(mode, sgn, 1'b0, guard, sticky);
      res         = up ? {sgn, ONE_EXP, {FRAC_W{1'b0}}}
                       : {sgn, {(EXP_W + FRAC_W){1'b0}}};
    end else begin
      sh          = SH_W'(FRAC_W - ue);
      mant        = {1'b0, 1'b1, fr};
      mask        = (ONE_M << sh) - ONE_M;
      low_mask    = (ONE_M << (sh - SH_W'(1))) - ONE_M;
      guard       = mant[sh - SH_W'(1)];
      sticky      = |(mant & low_mask);
      lsb         = mant[sh];
      inexact_raw = |(mant & mask);
      up          = rnd_incr(mode, sgn, lsb, guard, sticky);
      sum         = (mant & ~mask) + (up ? (ONE_M << sh) : '0);
      if (sum[MW-1]) res = {sgn, ex + EXP_W'(1), {FRAC_W{1'b0}}};
      else           res = {sgn, ex, sum[FRAC_W-1:0]};
    end
  end

endmodule

// File: rtl/fp_rint_unit.sv
module fp_rint_unit
  import fp_rint_pkg::*;
#(
  parameter int BUS_W  = 64,
  parameter int H_EXP  = 5,
  parameter int H_FRAC = 10,
  parameter int S_EXP  = 8,
  parameter int S_FRAC = 23,
  parameter int D_EXP  = 11,
  parameter int D_FRAC = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       fmt,
  input  logic [2:0]       rctl,
  input  logic [1:0]       dyn_mode,
  input  logic [BUS_W-1:0] operand,
  output logic             out_valid,
  output logic [BUS_W-1:0] result,
  output logic             inexact,
  output logic             invalid,
  output logic             undef
);

  localparam int NFMT = 3;

  rmode_e     mode;
  logic       exact_en;
  logic       rctl_undef;
  logic       fmt_undef;
  logic       is_undef;
  logic [BUS_W-1:0] core_res [NFMT];
  logic [NFMT-1:0]  core_inx;
  logic [NFMT-1:0]  core_snan;
  logic [BUS_W-1:0] sel_res;
  logic             sel_inx, sel_snan;

  fp_rint_decode u_dec (
    .rctl      (rctl),
    .dyn_mode  (dyn_mode),
    .mode      (mode),
    .exact_en  (exact_en),
    .rctl_undef(rctl_undef)
  );

  // Index 0 half, 1 single, 2 double.
  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    localparam int EW = (g == 0) ? H_EXP  : (g == 1) ? S_EXP  : D_EXP;
    localparam int FW = (g == 0) ? H_FRAC : (g == 1) ? S_FRAC : D_FRAC;
    logic [EW+FW:0] res_w;
    fp_rint_core #(.EXP_W(EW), .FRAC_W(FW)) u_core (
      .op         (operand[EW+FW:0]),
      .mode       (mode),
      .res        (res_w),
      .inexact_raw(core_inx[g]),
      .snan       (core_snan[g])
    );
    assign core_res[g] = BUS_W'(res_w);
  end

  assign fmt_undef = (fmt == FMT_RSVD);
  assign is_undef  = fmt_undef | rctl_undef;

  always_comb begin
    case (fmt)
      FMT_HALF:   begin sel_res = core_res[0]; sel_inx = core_inx[0]; sel_snan = core_snan[0]; end
      FMT_DOUBLE: begin sel_res = core_res[2]; sel_inx = core_inx[2]; sel_snan = core_snan[2]; end
      default:    begin sel_res = core_res[1]; sel_inx = core_inx[1]; sel_snan = core_snan[1]; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      inexact   <= 1'b0;
      invalid   <= 1'b0;
      undef     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= is_undef ? '0 : sel_res;
        inexact <= exact_en & sel_inx & ~is_undef;
        invalid <= sel_snan & ~is_undef;
        undef   <= is_undef;
      end
    end
  end

endmodule

// File: rtl/fp_rint_chk.sv
module fp_rint_chk #(
  parameter int BUS_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       fmt,
  input logic [2:0]       rctl,
  input logic [BUS_W-1:0] operand,
  input logic             out_valid,
  input logic [BUS_W-1:0] result,
  input logic             inexact,
  input logic             invalid,
  input logic             undef,
  input logic             exact_en,
  input logic             is_undef
);

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_rsvd_ctl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (rctl == 3'b101 || fmt == 2'b10)
      |=> undef && result == '0 && !inexact && !invalid);

  p_defined_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !is_undef |=> !undef);

  p_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !exact_en |=> !inexact);

  p_inf_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && fmt == 2'b00 && rctl != 3'b101 && operand[30:0] == 31'h7F80_0000
      |=> result[31:0] == $past(operand[31:0]) && !inexact);

  p_snan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && fmt == 2'b00 && rctl != 3'b101 && operand[30:23] == 8'hFF
      && !operand[22] && operand[21:0] != '0
      |=> invalid && result[22] && !inexact);

  p_upper_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && fmt == 2'b00 |=> result[BUS_W-1:32] == '0);

endmodule

bind fp_rint_unit fp_rint_chk #(.BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .fmt      (fmt),
  .rctl     (rctl),
  .operand  (operand),
  .out_valid(out_valid),
  .result   (result),
  .inexact  (inexact),
  .invalid  (invalid),
  .undef    (undef),
  .exact_en (exact_en),
  .is_undef (is_undef)
);

// File: tb/fp_rint_unit_bench.sv
module fp_rint_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [2:0]  rctl = 3'b000;
  logic [1:0]  dyn_mode = 2'b00;
  logic [63:0] operand = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        inexact, invalid, undef;

  int n_checks = 0;
  int n_errors = 0;

  logic [63:0] q_res  [$];
  logic [2:0]  q_flag [$];
  string       q_tag  [$];

  always #5 clk = ~clk;

  fp_rint_unit u_fp_rint_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .rctl(rctl),
    .dyn_mode(dyn_mode), .operand(operand), .out_valid(out_valid),
    .result(result), .inexact(inexact), .invalid(invalid), .undef(undef)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one strobe per call, expected item queued alongside.
  task automatic send(input logic [1:0] f, input logic [2:0] rc,
                      input logic [1:0] dm, input logic [63:0] op,
                      input logic [63:0] er, input logic ei, input logic ev,
                      input logic eu, input string tag);
    @(negedge clk);
    in_valid = 1'b1; fmt = f; rctl = rc; dyn_mode = dm; operand = op;
    q_res.push_back(er);
    q_flag.push_back({ei, ev, eu});
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compare each response with the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_res.size() == 0) begin
        check(1'b0, "R11 unexpected response", {63'b0, out_valid}, 64'd0);
      end else begin
        logic [63:0] er;
        logic [2:0]  ef;
        string       t;
        er = q_res.pop_front();
        ef = q_flag.pop_front();
        t  = q_tag.pop_front();
        check(result == er, {t, " result"}, result, er);
        check({inexact, invalid, undef} == ef, {t, " flags(inx,inv,und)"},
              {61'b0, inexact, invalid, undef}, {61'b0, ef});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && result == '0, "R11 reset state", result, 64'd0);
    check({inexact, invalid, undef} == 3'b000, "R11 reset flags",
          {61'b0, inexact, invalid, undef}, 64'd0);

    // R11 latency: single strobe, then gap
    send(2'b00, 3'b000, 2'b00, 64'h4020_0000, 64'h4000_0000, 0, 0, 0, "R2 RNE 2.5");
    idle();
    @(negedge clk);
    check(out_valid == 1'b0, "R11 idle after response", {63'b0, out_valid}, 64'd0);

    // R2 fixed modes, single precision
    send(2'b00, 3'b000, 2'b00, 64'h4060_0000, 64'h4080_0000, 0, 0, 0, "R2 RNE 3.5 carry");
    send(2'b00, 3'b000, 2'b00, 64'h3FC0_0000, 64'h4000_0000, 0, 0, 0, "R2 RNE 1.5");
    send(2'b00, 3'b001, 2'b00, 64'h4020_0000, 64'h4040_0000, 0, 0, 0, "R2 up 2.5");
    send(2'b00, 3'b010, 2'b00, 64'hC020_0000, 64'hC040_0000, 0, 0, 0, "R2 down -2.5");
    send(2'b00, 3'b011, 2'b00, 64'hC020_0000, 64'hC000_0000, 0, 0, 0, "R2 zero -2.5");
    // R3 ties away
    send(2'b00, 3'b100, 2'b00, 64'h4020_0000, 64'h4040_0000, 0, 0, 0, "R3 away 2.5");
    send(2'b00, 3'b100, 2'b00, 64'hBF00_0000, 64'hBF80_0000, 0, 0, 0, "R3 away -0.5");
    // R5 / R6 dynamic variants
    send(2'b00, 3'b110, 2'b00, 64'h402C_CCCD, 64'h4040_0000, 1, 0, 0, "R6 exact 2.7");
    send(2'b00, 3'b111, 2'b01, 64'h402C_CCCD, 64'h4040_0000, 0, 0, 0, "R5 silent up 2.7");
    send(2'b00, 3'b110, 2'b00, 64'h4040_0000, 64'h4040_0000, 0, 0, 0, "R6 exact 3.0");
    send(2'b00, 3'b110, 2'b11, 64'h3F33_3333, 64'h0000_0000, 1, 0, 0, "R5 dyn zero 0.7");
    send(2'b00, 3'b000, 2'b00, 64'h4020_0001, 64'h4040_0000, 0, 0, 0, "R5 fixed no inexact");
    // R10 small magnitudes
    send(2'b00, 3'b001, 2'b00, 64'hBE99_999A, 64'h8000_0000, 0, 0, 0, "R10 -0.3 up");
    send(2'b00, 3'b110, 2'b01, 64'h0000_0001, 64'h3F80_0000, 1, 0, 0, "R10 subnormal up");
    send(2'b00, 3'b000, 2'b00, 64'h3F00_0000, 64'h0000_0000, 0, 0, 0, "R10 RNE 0.5");
    send(2'b00, 3'b000, 2'b00, 64'h3F00_0001, 64'h3F80_0000, 0, 0, 0, "R10 RNE 0.5+ulp");
    // R7 zero / infinity
    send(2'b00, 3'b110, 2'b01, 64'h8000_0000, 64'h8000_0000, 0, 0, 0, "R7 -0");
    send(2'b00, 3'b110, 2'b01, 64'hFF80_0000, 64'hFF80_0000, 0, 0, 0, "R7 -inf");
    // R8 NaNs
    send(2'b00, 3'b110, 2'b00, 64'h7F80_0001, 64'h7FC0_0001, 0, 1, 0, "R8 sNaN");
    send(2'b00, 3'b110, 2'b00, 64'hFFC0_0123, 64'hFFC0_0123, 0, 0, 0, "R8 qNaN");
    // R9 large exponent
    send(2'b00, 3'b110, 2'b00, 64'h4B00_0001, 64'h4B00_0001, 0, 0, 0, "R9 single 2^23+1");
    idle();
    repeat (2) @(negedge clk);

    // R1 double and half
    send(2'b01, 3'b000, 2'b00, 64'h4004_0000_0000_0000, 64'h4000_0000_0000_0000, 0, 0, 0, "R1 double RNE 2.5");
    send(2'b01, 3'b110, 2'b01, 64'h4004_0000_0000_0000, 64'h4008_0000_0000_0000, 1, 0, 0, "R1 double dyn up 2.5");
    send(2'b01, 3'b010, 2'b00, 64'h3FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 0, 0, 0, "R1 double down 1.5");
    send(2'b01, 3'b001, 2'b00, 64'hBFD3_3333_3333_3333, 64'h8000_0000_0000_0000, 0, 0, 0, "R10 double -0.3 up");
    send(2'b01, 3'b110, 2'b00, 64'h4330_0000_0000_0001, 64'h4330_0000_0000_0001, 0, 0, 0, "R9 double 2^52+1");
    send(2'b11, 3'b000, 2'b00, 64'h4100, 64'h4000, 0, 0, 0, "R1 half RNE 2.5");
    send(2'b11, 3'b100, 2'b00, 64'h4100, 64'h4200, 0, 0, 0, "R3 half away 2.5");
    send(2'b11, 3'b110, 2'b00, 64'h7C01, 64'h7E01, 0, 1, 0, "R8 half sNaN");
    send(2'b11, 3'b010, 2'b00, 64'h0001, 64'h0000, 0, 0, 0, "R10 half subnormal down");
    send(2'b11, 3'b111, 2'b00, 64'h7C00, 64'h7C00, 0, 0, 0, "R7 half inf");
    // R12 upper bits ignored and cleared
    send(2'b00, 3'b000, 2'b00, 64'hDEAD_BEEF_4020_0000, 64'h4000_0000, 0, 0, 0, "R12 single upper junk");
    send(2'b11, 3'b001, 2'b00, 64'hFFFF_FFFF_FFFF_4100, 64'h4200, 0, 0, 0, "R12 half upper junk");
    // R1 / R4 reserved encodings
    send(2'b10, 3'b000, 2'b00, 64'h3F80_0000, 64'h0, 0, 0, 1, "R1 reserved format");
    send(2'b00, 3'b101, 2'b00, 64'h4020_0001, 64'h0, 0, 0, 1, "R4 reserved control");
    send(2'b00, 3'b000, 2'b00, 64'h7F80_0001, 64'h7FC0_0001, 0, 1, 0, "R4 recovery sNaN");
    idle();
    repeat (3) @(negedge clk);
    check(q_res.size() == 0, "R11 all responses seen", 64'(q_res.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule